// File: doc/BRIEF.md
# Receive-Level Hysteresis Flow Control

This block turns the fill level of a receive FIFO into an active-low "please stop sending" line toward the remote station. Software sets a trigger level and picks one of sixteen hysteresis codes. The hardware derives two thresholds from them. The halt threshold is the trigger plus the hysteresis amount, limited to the FIFO depth. The resume threshold is the trigger minus the hysteresis amount, limited at zero. When the count reaches the halt threshold the line goes high. It goes low again only once the count has drained to the resume threshold. Between the two thresholds the line keeps its last value, so the remote sender is not toggled on every byte.

A configuration bit chooses which modem pair carries the handshake: request/clear-to-send, or terminal-ready/set-ready. The matching active-low input from the remote end passes through a two-stage synchronizer and becomes a hold level for the local transmitter. The transmitter completes the character it is sending and starts no new one while that level is high.

When automatic control is off, each output pin simply reflects a software modem-control bit.

Top module: `rx_flow_hyst`

## Requirements
- R1: While reset is applied, the internal halt state is cleared, so the selected flow pin is low when control is enabled. The synchronizer stages load 1, so `txHold` is high when control is enabled.
- R2: With control enabled, a clock edge at which `rxCount` is at or above the halt threshold sets the selected pin high. The halt threshold is min(`trigLevel` + hysteresis, DEPTH).
- R3: With control enabled, a clock edge at which `rxCount` is at or below the resume threshold sets the selected pin low. The resume threshold is max(`trigLevel` − hysteresis, 0). If both thresholds are met at once, halt wins.
- R4: While `rxCount` lies strictly between the two thresholds, the selected pin keeps its previous value.
- R5: The hysteresis amount for code k on `hystSel` is 0 for k = 0 and 4·k for k = 1..13. Codes 14 and 15 give 52.
- R6: The halt threshold never exceeds DEPTH (64), so a full FIFO always halts. The resume threshold never goes below 0.
- R7: `usePairB` = 0 selects `rtsN`/`ctsN`, and `usePairB` = 1 selects `dtrN`/`dsrN`. The pin that is not selected equals the inverse of its software bit (`swRts` or `swDtr`; bit 1 drives the pin low).
- R8: With `flowEn` = 0, both pins equal the inverse of their software bits, `txHold` is 0, and each clock edge clears the halt state. After re-enabling, the pin starts low.
- R9: With control enabled, `txHold` equals the selected modem input as sampled two clock edges earlier.
- R10: A change of `rxCount` is reflected on the flow pin after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| rxCount | input | 7 | Current receive FIFO occupancy |
| trigLevel | input | 7 | Programmed receive trigger level |
| hystSel | input | 4 | Hysteresis code |
| usePairB | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| flowEn | input | 1 | Automatic flow control enable |
| swRts | input | 1 | Software request-to-send bit (1 = assert) |
| swDtr | input | 1 | Software terminal-ready bit (1 = assert) |
| ctsN | input | 1 | Clear-to-send from remote, active low |
| dsrN | input | 1 | Set-ready from remote, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| dtrN | output | 1 | Terminal-ready pin, active low |
| txHold | output | 1 | Hold request to the transmit engine |

## Verification
The bench uses the default parameters: DEPTH 64, a hysteresis unit of 4 capped at 52, and two synchronizer stages. With these values, trigger 60 with code 13 pushes the raw halt level to 112, so the clamp at 64 is exercised. Trigger 10 with code 15 drives the raw resume level below zero and also exercises the saturated codes. Code 0 makes both thresholds equal, which checks that halt wins when both are met. The two-stage synchronizer makes the one-edge delay on `txHold` observable as an intermediate sample.

// File: rtl/rx_flow_hyst_pkg.sv
package rx_flow_hyst_pkg;

  // Strobes from the threshold datapath to the control logic
  typedef struct packed {
    logic hitHalt;    // count at or above halt threshold
    logic hitResume;  // count at or below resume threshold
  } flowStrobe_t;

  // Hysteresis amount for a 4-bit code: linear steps, saturating at cap
  function automatic int hystStep(input logic [3:0] code, input int unit, input int cap);
    int raw;
    raw = int'(code) * unit;
    if (raw > cap) raw = cap;
    return raw;
  endfunction

endpackage

// File: rtl/rx_flow_hyst_thresh.sv
module rx_flow_hyst_thresh
  import rx_flow_hyst_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int CNT_W     = 7,
  parameter int HYST_UNIT = 4,
  parameter int HYST_CAP  = 52
) (
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [3:0]       hystSel,
  output flowStrobe_t      strobe
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] hystAmt;
  logic [SUM_W-1:0] rawHalt;
  logic [CNT_W-1:0] haltLvl;
  logic [CNT_W-1:0] resumeLvl;

  always_comb begin
    hystAmt = CNT_W'(hystStep(hystSel, HYST_UNIT, HYST_CAP));
    rawHalt = SUM_W'(trigLevel) + SUM_W'(hystAmt);
    // Upper clamp: never above the FIFO depth
    if (rawHalt > SUM_W'(DEPTH)) haltLvl = CNT_W'(DEPTH);
    else                         haltLvl = rawHalt[CNT_W-1:0];
    // Lower clamp: never below empty
    if (trigLevel > hystAmt) resumeLvl = trigLevel - hystAmt;
    else                     resumeLvl = '0;
    strobe.hitHalt   = (rxCount >= haltLvl);
    strobe.hitResume = (rxCount <= resumeLvl);
  end

endmodule

// File: rtl/rx_flow_hyst_ctrl.sv
module rx_flow_hyst_ctrl
  import rx_flow_hyst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  flowStrobe_t strobe,
  input  logic        usePairB,
  input  logic        flowEn,
  input  logic        swRts,
  input  logic        swDtr,
  input  logic        ctsN,
  input  logic        dsrN,
  output logic        rtsN,
  output logic        dtrN,
  output logic        txHold
);

  logic                   halted;
  logic                   selIn;
  logic [SYNC_STAGES-1:0] syncQ;

  // Halt state: halt has priority over resume at equal thresholds
  always_ff @(posedge clk) begin
    if (!rstN || !flowEn)     halted <= 1'b0;
    else if (strobe.hitHalt)  halted <= 1'b1;
    else if (strobe.hitResume) halted <= 1'b0;
  end

  assign selIn = usePairB ? dsrN : ctsN;

  // Synchronizer chain, resets to the holding value
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= selIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign txHold = flowEn & syncQ[SYNC_STAGES-1];
  assign rtsN   = (flowEn && !usePairB) ? halted : ~swRts;
  assign dtrN   = (flowEn &&  usePairB) ? halted : ~swDtr;

endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst
  import rx_flow_hyst_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int HYST_UNIT   = 4,
  parameter int HYST_CAP    = 52,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [3:0]       hystSel,
  input  logic             usePairB,
  input  logic             flowEn,
  input  logic             swRts,
  input  logic             swDtr,
  input  logic             ctsN,
  input  logic             dsrN,
  output logic             rtsN,
  output logic             dtrN,
  output logic             txHold
);

  flowStrobe_t strobe;

  rx_flow_hyst_thresh #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .HYST_UNIT(HYST_UNIT), .HYST_CAP(HYST_CAP)
  ) u_thresh (
    .rxCount(rxCount), .trigLevel(trigLevel), .hystSel(hystSel), .strobe(strobe)
  );

  rx_flow_hyst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .usePairB(usePairB), .flowEn(flowEn),
    .swRts(swRts), .swDtr(swDtr), .ctsN(ctsN), .dsrN(dsrN),
    .rtsN(rtsN), .dtrN(dtrN), .txHold(txHold)
  );

endmodule

// File: rtl/rx_flow_hyst_chk.sv
module rx_flow_hyst_chk #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] trigLevel,
  input logic             usePairB,
  input logic             flowEn,
  input logic             swRts,
  input logic             swDtr,
  input logic             ctsN,
  input logic             rtsN,
  input logic             dtrN,
  input logic             txHold
);

  // A full FIFO always halts the sender (clamp at depth)
  assert_full_halts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && !usePairB && rxCount >= CNT_W'(DEPTH)) |=> (!flowEn || usePairB || rtsN));

  // A rising pin under steady configuration came from a count at or above trigger
  assert_rise_above_trig_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rtsN) && flowEn && $past(flowEn) && !usePairB && !$past(usePairB)
     && $past(trigLevel) <= CNT_W'(DEPTH)) |-> ($past(rxCount) >= $past(trigLevel)));

  // A falling pin under steady configuration came from a count at or below trigger
  assert_fall_below_trig_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rtsN) && flowEn && $past(flowEn) && !usePairB && !$past(usePairB))
    |-> ($past(rxCount) <= $past(trigLevel)));

  // Unselected pin mirrors its software bit
  assert_unselected_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && !usePairB) |-> (dtrN == !swDtr));

  // Disabled: software bits drive the pins, transmitter free
  assert_disabled_soft_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!flowEn) |-> (rtsN == !swRts && !txHold));

  if (SYNC_STAGES == 2) begin : g_sync2
    // Remote stop seen two edges ago holds the transmitter
    assert_remote_stop_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
      (flowEn && !$past(usePairB, 2) && $past(ctsN, 2)) |-> txHold);
  end

endmodule

bind rx_flow_hyst rx_flow_hyst_chk #(
  .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .rxCount(rxCount), .trigLevel(trigLevel),
  .usePairB(usePairB), .flowEn(flowEn), .swRts(swRts), .swDtr(swDtr),
  .ctsN(ctsN), .rtsN(rtsN), .dtrN(dtrN), .txHold(txHold)
);

// File: tb/rx_flow_hyst_bench.sv
module rx_flow_hyst_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic clk = 1'b0;
  logic rstN;
  logic [6:0] rxCount, trigLevel;
  logic [3:0] hystSel;
  logic usePairB, flowEn, swRts, swDtr, ctsN, dsrN;
  logic rtsN, dtrN, txHold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_hyst u_rx_flow_hyst (
    .clk(clk), .rstN(rstN), .rxCount(rxCount), .trigLevel(trigLevel), .hystSel(hystSel),
    .usePairB(usePairB), .flowEn(flowEn), .swRts(swRts), .swDtr(swDtr),
    .ctsN(ctsN), .dsrN(dsrN), .rtsN(rtsN), .dtrN(dtrN), .txHold(txHold)
  );

  // {flowEn, usePairB, swRts, swDtr, trig[6:0], hyst[3:0], count[6:0], expRtsN, expDtrN}
  localparam logic [23:0] VEC [NVEC] = '{
    {4'b1011, 7'd32, 4'd5,  7'd10, 2'b00},  // R4 below resume, stays low
    {4'b1011, 7'd32, 4'd5,  7'd51, 2'b00},  // R4 one short of 52
    {4'b1011, 7'd32, 4'd5,  7'd52, 2'b10},  // R2 R5 halt at 32+20
    {4'b1011, 7'd32, 4'd5,  7'd40, 2'b10},  // R4 holds high
    {4'b1011, 7'd32, 4'd5,  7'd13, 2'b10},  // R4 one above 12
    {4'b1011, 7'd32, 4'd5,  7'd12, 2'b00},  // R3 resume at 32-20
    {4'b1011, 7'd32, 4'd5,  7'd30, 2'b00},  // R4
    {4'b1011, 7'd20, 4'd0,  7'd19, 2'b00},  // R5 code 0
    {4'b1011, 7'd20, 4'd0,  7'd20, 2'b10},  // R3 halt wins at equality
    {4'b1011, 7'd20, 4'd0,  7'd19, 2'b00},  // R3 resume below trigger
    {4'b1011, 7'd60, 4'd13, 7'd63, 2'b00},  // R6 clamped halt is 64
    {4'b1011, 7'd60, 4'd13, 7'd64, 2'b10},  // R6 full halts
    {4'b1011, 7'd60, 4'd13, 7'd9,  2'b10},  // R5 resume at 8
    {4'b1011, 7'd60, 4'd13, 7'd8,  2'b00},  // R3
    {4'b1011, 7'd10, 4'd15, 7'd61, 2'b00},  // R5 code 15 saturates: halt 62
    {4'b1011, 7'd10, 4'd15, 7'd62, 2'b10},  // R2
    {4'b1011, 7'd10, 4'd15, 7'd1,  2'b10},  // R6 resume clamped at 0
    {4'b1011, 7'd10, 4'd15, 7'd0,  2'b00},  // R6
    {4'b1101, 7'd32, 4'd2,  7'd40, 2'b11},  // R7 DTR pair halts at 40, RTS soft
    {4'b1101, 7'd32, 4'd2,  7'd25, 2'b11},  // R7 hold
    {4'b1101, 7'd32, 4'd2,  7'd24, 2'b10},  // R7 resume at 24
    {4'b1101, 7'd32, 4'd2,  7'd30, 2'b10},  // R7
    {4'b0001, 7'd32, 4'd5,  7'd60, 2'b10},  // R8 disabled follows soft bits
    {4'b1011, 7'd32, 4'd5,  7'd40, 2'b00}   // R8 halt state was cleared
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxCount = '0; trigLevel = 7'd32; hystSel = 4'd5;
    usePairB = 1'b0; flowEn = 1'b1; swRts = 1'b1; swDtr = 1'b1;
    ctsN = 1'b0; dsrN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rtsN in reset", rtsN, 1'b0);
    check("R1 txHold in reset", txHold, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: drive at negedge, result after one posedge (R10)
    for (int i = 0; i < NVEC; i++) begin
      {flowEn, usePairB, swRts, swDtr} = VEC[i][23:20];
      trigLevel = VEC[i][19:13];
      hystSel   = VEC[i][12:9];
      rxCount   = VEC[i][8:2];
      @(negedge clk);
      check($sformatf("R10 vec%0d rtsN", i), rtsN, VEC[i][1]);
      check($sformatf("R10 vec%0d dtrN", i), dtrN, VEC[i][0]);
    end

    // Transmit hold through the synchronizer (R9)
    flowEn = 1'b1; usePairB = 1'b0; rxCount = '0; ctsN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ctsN high holds", txHold, 1'b1);
    ctsN = 1'b0;
    @(negedge clk);
    check("R9 one edge still held", txHold, 1'b1);
    @(negedge clk);
    check("R9 released after two edges", txHold, 1'b0);
    usePairB = 1'b1; dsrN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 DSR pair holds", txHold, 1'b1);
    check("R7 rtsN soft with DTR pair", rtsN, 1'b0);
    flowEn = 1'b0;
    #1;
    check("R8 disabled frees tx", txHold, 1'b0);
    @(negedge clk);
    check("R8 dtrN soft when disabled", dtrN, 1'b0);
    finishRun();
  end

endmodule